// File: doc/BRIEF.md
# Arbitrated Test-and-Set Lock Unit

This block holds a small set of one-bit lock words that several requesters share over a single bus. Each requester can post one of three operations against a chosen lock word: a plain read that returns the value and changes nothing, a swap that returns the old value and leaves the word at 1 within the same bus operation, and a release that clears the word. A lock word of 0 means free and 1 means taken. Only one operation is carried out per cycle. A round-robin arbiter picks it, so requests that collide are put in a strict order and nothing else can come between the read and the set of a swap.

Software normally spins on plain reads until it sees 0 and then tries a swap. Among swaps that collide on a free word, exactly one gets 0 back. Every later swap gets back the 1 that the winner wrote. The unit records which requester took each word. A release from any other requester, or a release of a free word, is reported as an error and leaves the word unchanged.

Top module: `lock_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every lock word is 0 (free), and no grant, response or error is active.
- R2: In each cycle at most one bit of `req_grant` is set. It is set only for a requester whose `req_valid` bit is set, and some bit is set whenever any `req_valid` bit is set.
- R3: The grant goes to the first requester with `req_valid` set, searching upward and wrapping around from the index after the last granted requester. After reset the search starts at requester 0.
- R4: A requester granted in cycle t gets `resp_valid` for exactly the one cycle t+1. No other requester's `resp_valid` is set in that cycle.
- R5: A read (op code 0, and also the unused code 3) returns the current value of the addressed lock word in `resp_old` and changes no state.
- R6: A swap (op code 1) returns the old value and leaves the word at 1 in the same operation. A swap that finds the word free makes its requester the holder. When several requesters swap the same free word, exactly one of them gets 0.
- R7: A release (op code 2) by the holder of a taken word returns the old value 1, clears the word to 0 and does not set `resp_err`.
- R8: A release by a requester that does not hold the word, or a release of a free word, returns the old value with `resp_err` set and leaves the word and its holder unchanged.
- R9: The lock words are independent of each other. An operation on one word does not change any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | One request bit per requester |
| req_op | input | 2*N_REQ | Op code per requester (0 read, 1 swap, 2 release, 3 read) |
| req_idx | input | N_REQ*clog2(N_LOCK) | Lock word index per requester |
| req_grant | output | N_REQ | Grant for this cycle, at most one bit set |
| resp_valid | output | N_REQ | One-cycle response pulse per requester |
| resp_old | output | N_REQ | Old lock value returned to the requester |
| resp_err | output | N_REQ | Release refused (requester is not the holder) |

## Verification
The grant is combinational, so the bench reads `req_grant` a moment after it drives the requests, in the same cycle. The response of that grant, meaning the valid pulse, the old value and the error flag, is registered once, so the bench samples it at the falling edge that follows the next rising edge. A reference model in the bench tracks the lock words, the holders and the round-robin pointer, and updates them only for the requester it predicts will be granted. Because of this, every expected response, including a refused release or a losing swap, is fixed before the clock edge that produces it.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    LK_READ  = 2'd0,
    LK_SWAP  = 2'd1,
    LK_FREE  = 2'd2,
    LK_READ2 = 2'd3
  } lk_op_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  output logic [N-1:0]   gnt,
  output logic [IDW-1:0] gnt_idx
);
  logic [IDW-1:0] last_q, last_d;
  logic           found;

  always_comb begin
    int c;
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(last_q) + k) % N;
      if (!found && req[c]) begin
        found      = 1'b1;
        gnt[c]     = 1'b1;
        gnt_idx    = IDW'(c);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (found) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDW'(N - 1);
    else        last_q <= last_d;
  end

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  assert_no_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/lock_table.sv
module lock_table
  import lock_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int N_LOCK = 4,
  localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int LW  = (N_LOCK > 1) ? $clog2(N_LOCK) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  lk_op_e         op,
  input  logic [LW-1:0]  idx,
  input  logic [IDW-1:0] who,
  output logic           old_val,
  output logic           err
);
  logic [N_LOCK-1:0] locked_q, locked_d;
  logic [IDW-1:0]    owner_q [N_LOCK];
  logic [IDW-1:0]    owner_d [N_LOCK];
  logic              holder;
  logic              do_swap, do_free;

  always_comb begin
    old_val = locked_q[idx];
    holder  = locked_q[idx] && (owner_q[idx] == who);
    do_swap = fire && (op == LK_SWAP);
    do_free = fire && (op == LK_FREE);
    err     = do_free && !holder;
  end

  always_comb begin
    locked_d = locked_q;
    owner_d  = owner_q;
    if (do_swap) begin
      locked_d[idx] = 1'b1;
      if (!locked_q[idx]) owner_d[idx] = who;
    end
    if (do_free && holder) locked_d[idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= '0;
      for (int i = 0; i < N_LOCK; i++) owner_q[i] <= '0;
    end else if (fire) begin
      locked_q <= locked_d;
      owner_q  <= owner_d;
    end
  end

  assert_swap_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_swap |=> locked_q[$past(idx)]);
  assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_free && !err) |=> !locked_q[$past(idx)]);
  assert_refused_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(locked_q));
  assert_read_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op == LK_READ || op == LK_READ2)) |=> $stable(locked_q));
endmodule

// File: rtl/resp_reg.sv
module resp_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] gnt,
  input  logic         old_val,
  input  logic         err,
  output logic [N-1:0] resp_valid,
  output logic [N-1:0] resp_old,
  output logic [N-1:0] resp_err
);
  logic [N-1:0] v_d, o_d, e_d;

  always_comb begin
    v_d = gnt;
    o_d = gnt & {N{old_val}};
    e_d = gnt & {N{err}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= '0;
      resp_old   <= '0;
      resp_err   <= '0;
    end else begin
      resp_valid <= v_d;
      resp_old   <= o_d;
      resp_err   <= e_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_resp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |=> resp_valid[i]);
    assert_resp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid[i] && !gnt[i]) |=> !resp_valid[i]);
  end
  assert_single_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(resp_valid) <= 1);
  assert_err_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_err & ~resp_valid) == '0);
endmodule

// File: rtl/lock_unit.sv
module lock_unit
  import lock_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int N_LOCK = 4,
  localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int LW  = (N_LOCK > 1) ? $clog2(N_LOCK) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_REQ-1:0]      req_valid,
  input  logic [2*N_REQ-1:0]    req_op,
  input  logic [N_REQ*LW-1:0]   req_idx,
  output logic [N_REQ-1:0]      req_grant,
  output logic [N_REQ-1:0]      resp_valid,
  output logic [N_REQ-1:0]      resp_old,
  output logic [N_REQ-1:0]      resp_err
);
  logic [IDW-1:0] gnt_idx;
  logic           fire;
  lk_op_e         sel_op;
  logic [LW-1:0]  sel_idx;
  logic           old_val, err;

  rr_arbiter #(.N(N_REQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(req_grant), .gnt_idx(gnt_idx)
  );

  always_comb begin
    fire    = |req_grant;
    sel_op  = lk_op_e'(req_op[gnt_idx*2 +: 2]);
    sel_idx = req_idx[gnt_idx*LW +: LW];
  end

  lock_table #(.N_REQ(N_REQ), .N_LOCK(N_LOCK)) u_tab (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(sel_op),
    .idx(sel_idx), .who(gnt_idx), .old_val(old_val), .err(err)
  );

  resp_reg #(.N(N_REQ)) u_resp (
    .clk(clk), .rst_n(rst_n), .gnt(req_grant), .old_val(old_val),
    .err(err), .resp_valid(resp_valid), .resp_old(resp_old),
    .resp_err(resp_err)
  );

  assert_no_early_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant == '0) |=> (resp_valid == '0));
endmodule

// File: tb/test_lock_unit.sv
module test_lock_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int NL = 4;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [N*LW-1:0] req_idx = '0;
  logic [N-1:0]    req_grant, resp_valid, resp_old, resp_err;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_lock [NL];
  int m_own  [NL];
  int m_last;
  int zeros;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_unit #(.N_REQ(N), .N_LOCK(NL)) i_lock_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_idx(req_idx), .req_grant(req_grant), .resp_valid(resp_valid),
    .resp_old(resp_old), .resp_err(resp_err)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rr_pick(logic [N-1:0] r, int last);
    for (int k = 1; k <= N; k++) begin
      if (r[(last + k) % N]) return (last + k) % N;
    end
    return -1;
  endfunction

  task automatic set_req(int who, int op, int idx);
    req_valid[who] = 1'b1;
    req_op[who*2 +: 2] = 2'(op);
    req_idx[who*LW +: LW] = LW'(idx);
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic step();
    int g, op, idx;
    bit eold, eerr;
    string tag;
    logic [N-1:0] egnt;
    #1;
    g = rr_pick(req_valid, m_last);
    egnt = (g >= 0) ? (N'(1) << g) : '0;
    chk(req_grant == egnt, "R2/R3", "grant", int'(req_grant), int'(egnt));
    eold = 0; eerr = 0; tag = "R5";
    if (g >= 0) begin
      op  = int'(req_op[g*2 +: 2]);
      idx = int'(req_idx[g*LW +: LW]);
      eold = m_lock[idx];
      m_last = g;
      if (op == 1) begin
        tag = "R6";
        if (!m_lock[idx]) m_own[idx] = g;
        m_lock[idx] = 1;
      end else if (op == 2) begin
        if (m_lock[idx] && m_own[idx] == g) begin
          tag = "R7"; m_lock[idx] = 0;
        end else begin
          tag = "R8"; eerr = 1;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(resp_valid == egnt, "R4", "resp_valid", int'(resp_valid), int'(egnt));
    if (g >= 0) begin
      chk(resp_old[g] == eold, tag, "resp_old", int'(resp_old[g]), int'(eold));
      chk(resp_err[g] == eerr, tag, "resp_err", int'(resp_err[g]), int'(eerr));
      if (op == 1 && eold == 0) zeros++;
    end
    req_valid = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NL; i++) begin m_lock[i] = 0; m_own[i] = 0; end
    m_last = N - 1;
    repeat (3) @(negedge clk);
    chk(resp_valid == '0 && req_grant == '0, "R1", "idle in reset",
        int'(resp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(resp_valid == '0 && resp_err == '0, "R1", "idle after reset",
        int'(resp_valid), 0);

    // R1: every lock reads free after reset
    for (int l = 0; l < NL; l++) begin set_req(l % N, 0, l); step(); end

    // R6: all requesters swap lock 0 together, held until each is served
    zeros = 0;
    for (int k = 0; k < N; k++) begin
      for (int r = k; r < N; r++) set_req(r, 1, 0);
      step();
    end
    chk(zeros == 1, "R6", "winning swaps", zeros, 1);

    // R8: release by non-holder refused; read still shows 1
    set_req((m_own[0] + 1) % N, 2, 0); step();
    set_req(2, 3, 0); step();
    // R9: another lock still free, swap takes it
    set_req(1, 1, 2); step();
    set_req(3, 0, 1); step();
    // R7: holder releases; R5 read returns 0
    set_req(m_own[0], 2, 0); step();
    set_req(3, 0, 0); step();
    // R8: release of a free lock
    set_req(0, 2, 0); step();

    // R3: rotation with all requesters reading every cycle
    for (int k = 0; k < 2 * N; k++) begin
      for (int r = 0; r < N; r++) set_req(r, 0, 3);
      step();
    end

    // mixed random traffic
    for (int c = 0; c < 600; c++) begin
      for (int r = 0; r < N; r++) begin
        if ($urandom % 2 == 1) set_req(r, int'($urandom % 4), int'($urandom % NL));
      end
      step();
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule